// File: doc/BRIEF.md
# Watchdog and Reset Generator

This block is the single source of the synchronous chip reset. Three causes feed it: an external active-low reset pin, a power-up hold-off, and a watchdog timeout. The block runs on the oscillator clock. It divides that clock by two to get a one-cycle-in-two bus tick. The reset output changes only on bus ticks, so every consumer sees a reset that lines up with the bus clock.

When the power-up reset input is released, the block keeps the chip in reset for a fixed number of bus cycles, which lets the oscillator settle. The watchdog is a free-running counter on the oscillator clock. Software restarts it by writing, during a bus tick, a byte with bit 0 clear to a single service address. That address otherwise holds read-only vector data, so reads of it do nothing to the watchdog. A static enable stands in for a factory option that removes the watchdog. A test-voltage flag holds the watchdog idle while it is present.

Top module: `wdr_top`

## Requirements
- R1: `chipRst` changes only on oscillator edges at which `busTick` is high. `busTick` alternates between 1 and 0 on every oscillator cycle.
- R2: While `coldRstN` is low, `chipRst` is 1. After `coldRstN` rises, `chipRst` stays 1 until POR_CYCLES bus ticks have been counted, and it falls at oscillator edge 2·POR_CYCLES+2 after the release.
- R3: `extRstN` passes through two synchronizer flops. `chipRst` is 1 within 4 oscillator edges after `extRstN` falls, is still 1 two edges after `extRstN` rises, and is 0 four edges after it rises.
- R4: If no service write occurs, the watchdog raises `chipRst` 2^WDOG_BITS oscillator cycles after the previous reset released.
- R5: A write (`busWrEn`=1 during a bus tick) to SERVICE_ADDR with data bit 0 equal to 0 restarts the watchdog count. Regular servicing keeps `chipRst` at 0.
- R6: Three kinds of access leave the watchdog count unchanged: a write to SERVICE_ADDR with data bit 0 equal to 1, a write with bit 0 clear to any other address, and an access to SERVICE_ADDR with `busWrEn` low (a read).
- R7: A watchdog reset holds `chipRst` high for exactly one bus cycle (2 oscillator cycles) and clears the counter. The next timeout comes a full period after release.
- R8: With `wdogEnable` low, the counter is held at zero and no watchdog reset occurs. A full period is counted after the watchdog is re-enabled.
- R9: While `testVolt` is high, the counter is held at zero and no watchdog reset occurs. A full period is counted after `testVolt` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| oscClk | input | 1 | Oscillator clock |
| coldRstN | input | 1 | Power-up reset, active low, asynchronous assert |
| extRstN | input | 1 | External reset pin, active low, asynchronous |
| wdogEnable | input | 1 | Static watchdog enable (factory option) |
| testVolt | input | 1 | Test-voltage indication, suppresses the watchdog |
| busWrEn | input | 1 | Bus write strobe, sampled on bus ticks |
| busAddr | input | ADDR_W | Bus address |
| busWrData | input | DATA_W | Bus write data (only bit 0 is used) |
| busTick | output | 1 | High on oscillator cycles that end a bus cycle |
| chipRst | output | 1 | Synchronous chip reset, active high |

## Verification
The watchdog is run without any service to measure its full period and the width of its reset pulse. It is also run with periodic valid service writes, which shows whether the restart path works at all. Near-miss accesses are then applied: bit 0 set, the wrong address, and a read of the service address. The elapsed time to the next reset shows whether any of these disturbed the count. Disable and test-voltage runs separate "held idle" from "counting but masked" by timing the reset after the inhibit is lifted. The external-reset run checks the two-flop latency on both edges of the pin.

// File: rtl/wdr_pkg.sv
package wdr_pkg;
  typedef struct packed {
    logic clear;
    logic run;
  } wdogStrobe_t;
endpackage

// File: rtl/wdr_wdog_dp.sv
module wdr_wdog_dp
  import wdr_pkg::*;
#(
  parameter int WDOG_BITS = 18
) (
  input  logic        oscClk,
  input  logic        coldRstN,
  input  wdogStrobe_t strobes,
  output logic        wdogExpire
);
  localparam logic [WDOG_BITS-1:0] CntMax = '1;

  logic [WDOG_BITS-1:0] wdogCnt;

  always_ff @(posedge oscClk or negedge coldRstN) begin
    if (!coldRstN) begin
      wdogCnt <= '0;
    end else if (strobes.clear || !strobes.run) begin
      wdogCnt <= '0;
    end else begin
      wdogCnt <= wdogCnt + 1'b1;
    end
  end

  assign wdogExpire = strobes.run && (wdogCnt == CntMax);

  // R5 / R7: a clear strobe always leaves the counter at zero
  assert_clear_zeroes_R5: assert property (@(posedge oscClk) disable iff (!coldRstN)
    strobes.clear |=> (wdogCnt == '0));

  // R8 / R9: an inhibited watchdog never advances
  assert_idle_when_off_R8: assert property (@(posedge oscClk) disable iff (!coldRstN)
    !strobes.run |=> (wdogCnt == '0));
endmodule

// File: rtl/wdr_ctrl.sv
module wdr_ctrl
  import wdr_pkg::*;
#(
  parameter int ADDR_W       = 13,
  parameter int SERVICE_ADDR = 'h1FF0,
  parameter int POR_CYCLES   = 4064
) (
  input  logic              oscClk,
  input  logic              coldRstN,
  input  logic              extRstN,
  input  logic              wdogEnable,
  input  logic              testVolt,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrBit0,
  input  logic              wdogExpire,
  output wdogStrobe_t       strobes,
  output logic              busTick,
  output logic              chipRst
);
  localparam int PorW = $clog2(POR_CYCLES + 1);
  localparam logic [PorW-1:0] PorLast = PorW'(POR_CYCLES);
  localparam logic [ADDR_W-1:0] SvcAddr = ADDR_W'(SERVICE_ADDR);

  logic            busPhase;
  logic [1:0]      extSync;
  logic [PorW-1:0] porCnt;
  logic            porBusy;
  logic            wdogPend;
  logic            serviceHit;
  logic            rstReq;
  logic            chipRstQ;

  assign porBusy    = (porCnt != PorLast);
  assign serviceHit = busPhase && busWrEn && (busAddr == SvcAddr) && !busWrBit0;
  assign rstReq     = extSync[1] || porBusy || wdogPend || wdogExpire;

  always_ff @(posedge oscClk or negedge coldRstN) begin
    if (!coldRstN) begin
      busPhase <= 1'b0;
      extSync  <= 2'b11;
      porCnt   <= '0;
      wdogPend <= 1'b0;
      chipRstQ <= 1'b1;
    end else begin
      busPhase <= ~busPhase;
      extSync  <= {extSync[0], ~extRstN};
      if (busPhase && porBusy) porCnt <= porCnt + 1'b1;
      wdogPend <= (wdogPend || wdogExpire) && !busPhase;
      if (busPhase) chipRstQ <= rstReq;
    end
  end

  assign strobes.clear = chipRstQ || serviceHit;
  assign strobes.run   = wdogEnable && !testVolt;
  assign busTick       = busPhase;
  assign chipRst       = chipRstQ;

  // R1: the reset output only moves on bus ticks
  assert_rst_on_tick_R1: assert property (@(posedge oscClk) disable iff (!coldRstN)
    !busPhase |=> $stable(chipRstQ));

  // R2: power-up hold-off keeps reset asserted
  assert_por_holds_R2: assert property (@(posedge oscClk) disable iff (!coldRstN)
    (porBusy && busPhase) |=> chipRstQ);

  // R3: a synchronized external reset reaches the output
  assert_ext_reaches_R3: assert property (@(posedge oscClk) disable iff (!coldRstN)
    (extSync[1] && busPhase) |=> chipRstQ);

  // R7: every reset pulse lasts at least a full bus cycle
  assert_min_width_R7: assert property (@(posedge oscClk) disable iff (!coldRstN)
    $rose(chipRstQ) |=> chipRstQ);
endmodule

// File: rtl/wdr_top.sv
module wdr_top #(
  parameter int ADDR_W       = 13,
  parameter int DATA_W       = 8,
  parameter int SERVICE_ADDR = 'h1FF0,
  parameter int POR_CYCLES   = 4064,
  parameter int WDOG_BITS    = 18
) (
  input  logic              oscClk,
  input  logic              coldRstN,
  input  logic              extRstN,
  input  logic              wdogEnable,
  input  logic              testVolt,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic              busTick,
  output logic              chipRst
);
  import wdr_pkg::*;

  wdogStrobe_t strobes;
  logic        wdogExpire;
  logic        unusedDataBits;

  assign unusedDataBits = ^busWrData[DATA_W-1:1];

  wdr_ctrl #(
    .ADDR_W(ADDR_W),
    .SERVICE_ADDR(SERVICE_ADDR),
    .POR_CYCLES(POR_CYCLES)
  ) ctrl (
    .oscClk(oscClk),
    .coldRstN(coldRstN),
    .extRstN(extRstN),
    .wdogEnable(wdogEnable),
    .testVolt(testVolt),
    .busWrEn(busWrEn),
    .busAddr(busAddr),
    .busWrBit0(busWrData[0]),
    .wdogExpire(wdogExpire),
    .strobes(strobes),
    .busTick(busTick),
    .chipRst(chipRst)
  );

  wdr_wdog_dp #(
    .WDOG_BITS(WDOG_BITS)
  ) wdog (
    .oscClk(oscClk),
    .coldRstN(coldRstN),
    .strobes(strobes),
    .wdogExpire(wdogExpire)
  );
endmodule

// File: tb/tb_wdr_top.sv
module tb_wdr_top;
  localparam int ADDR_W  = 13;
  localparam int DATA_W  = 8;
  localparam int SVC     = 'h1FF0;
  localparam int POR     = 20;
  localparam int WBITS   = 10;
  localparam int PERIOD  = 1 << WBITS;

  logic              oscClk = 1'b0;
  logic              coldRstN = 1'b0;
  logic              extRstN = 1'b1;
  logic              wdogEnable = 1'b1;
  logic              testVolt = 1'b0;
  logic              busWrEn = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [DATA_W-1:0] busWrData = '0;
  logic              busTick;
  logic              chipRst;

  int checks = 0;
  int errors = 0;

  always #5 oscClk = ~oscClk;

  wdr_top #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SERVICE_ADDR(SVC),
    .POR_CYCLES(POR), .WDOG_BITS(WBITS)
  ) dut (
    .oscClk(oscClk), .coldRstN(coldRstN), .extRstN(extRstN),
    .wdogEnable(wdogEnable), .testVolt(testVolt), .busWrEn(busWrEn),
    .busAddr(busAddr), .busWrData(busWrData), .busTick(busTick),
    .chipRst(chipRst)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge oscClk);
    #1;
  endtask

  task automatic powerUp();
    coldRstN = 1'b0;
    step(2);
    check(chipRst == 1'b1, "R2 reset state", chipRst, 1);
    coldRstN = 1'b1;
    step(2 * POR);
    check(chipRst == 1'b1, "R2 hold-off end-2", chipRst, 1);
    step(2);
    check(chipRst == 1'b0, "R2 release", chipRst, 0);
  endtask

  task automatic serviceWrite(input int addr, input int data);
    busWrEn = 1'b1;
    busAddr = ADDR_W'(addr);
    busWrData = DATA_W'(data);
    step(2);
    busWrEn = 1'b0;
  endtask

  task automatic untilReset(input int limit, output int n);
    n = 0;
    while (chipRst == 1'b0 && n < limit) begin
      step(1);
      n++;
    end
  endtask

  task automatic t_por();
    int t0;
    powerUp();
    t0 = busTick;
    step(1);
    check(busTick != t0, "R1 tick alternates", busTick, 1 - t0);
    step(1);
    check(busTick == t0, "R1 tick period", busTick, t0);
  endtask

  task automatic t_timeout();
    int n;
    int w;
    powerUp();
    untilReset(PERIOD + 50, n);
    check(n >= PERIOD - 2 && n <= PERIOD + 2, "R4 timeout period", n, PERIOD);
    w = 0;
    while (chipRst == 1'b1 && w < 20) begin
      w++;
      step(1);
    end
    check(w == 2, "R7 reset width", w, 2);
    untilReset(PERIOD + 50, n);
    check(n >= PERIOD - 3 && n <= PERIOD + 2, "R7 period after wdog reset", n, PERIOD);
  endtask

  task automatic t_service();
    int n;
    powerUp();
    for (int i = 0; i < 6; i++) begin
      step(500);
      serviceWrite(SVC, 'hFE);
      check(chipRst == 1'b0, "R5 serviced no reset", chipRst, 0);
    end
    untilReset(PERIOD + 50, n);
    check(n >= PERIOD - 6 && n <= PERIOD + 2, "R5 restart point", n, PERIOD);
  endtask

  task automatic t_ignored();
    int n;
    int e;
    powerUp();
    step(400);
    serviceWrite(SVC, 'h01);
    step(100);
    serviceWrite(SVC ^ 1, 'h00);
    busAddr = ADDR_W'(SVC);
    busWrData = '0;
    step(50);
    e = 400 + 2 + 100 + 2 + 50;
    untilReset(PERIOD + 50, n);
    check(e + n >= PERIOD - 2 && e + n <= PERIOD + 2, "R6 ignored accesses", e + n, PERIOD);
  endtask

  task automatic t_disable();
    int n;
    wdogEnable = 1'b0;
    powerUp();
    step(3000);
    check(chipRst == 1'b0, "R8 disabled no reset", chipRst, 0);
    wdogEnable = 1'b1;
    untilReset(PERIOD + 50, n);
    check(n >= PERIOD - 2 && n <= PERIOD + 3, "R8 full period after enable", n, PERIOD);
  endtask

  task automatic t_testv();
    int n;
    powerUp();
    step(500);
    testVolt = 1'b1;
    step(2000);
    check(chipRst == 1'b0, "R9 suppressed no reset", chipRst, 0);
    testVolt = 1'b0;
    untilReset(PERIOD + 50, n);
    check(n >= PERIOD - 2 && n <= PERIOD + 3, "R9 full period after removal", n, PERIOD);
  endtask

  task automatic t_ext();
    int n;
    powerUp();
    step(100);
    extRstN = 1'b0;
    step(4);
    check(chipRst == 1'b1, "R3 assert latency", chipRst, 1);
    step(10);
    extRstN = 1'b1;
    step(2);
    check(chipRst == 1'b1, "R3 sync delay on release", chipRst, 1);
    step(2);
    check(chipRst == 1'b0, "R3 release latency", chipRst, 0);
    untilReset(PERIOD + 50, n);
    check(n >= PERIOD - 3 && n <= PERIOD + 2, "R3 counter cleared by ext reset", n, PERIOD);
  endtask

  initial begin
    t_por();
    t_timeout();
    t_service();
    t_ignored();
    t_disable();
    t_testv();
    t_ext();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge oscClk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule